// File: doc/BRIEF.md
# Transmit Holding Status and FIFO Data-Request Logic

This block sits between the CPU write path and the serializer of an asynchronous or LIN-style transmitter. It owns the one-byte holding register that the serializer loads from, an optional byte FIFO that feeds that register, and the three transmit status flags. It also produces the single interrupt request that combines them. The three flags are holding-empty, bus-idle and FIFO data-request. The serializer pulses `load_stb` when it copies the holding byte into its shift register, and it drives `tx_busy` while it shifts.

With `fifo_en` low, CPU writes go straight into the holding register. With `fifo_en` high, writes go into the FIFO. The FIFO then moves its oldest byte into the holding register whenever the holding register is empty. The data-request flag tells software that the FIFO has run dry. Software clears it by writing 0, and it also clears when the FIFO fills.

Top module: `txq_status`

## Requirements
- R1: While reset is active, and in the first cycle after it, the outputs are: `tdre`=1, `tbi`=0, `drq`=0, `fifo_cnt`=0, `hold_vld`=0, `irq`=0.
- R2: With `fifo_en`=0, a write loads `wr_data` into the holding register and clears `tdre` at the next edge. A `load_stb` while the holding register is full empties it and sets `tdre` at the next edge. A `load_stb` while the holding register is empty changes nothing.
- R3: `tbi` becomes 1 at an edge where the holding register and the FIFO end up empty while `tx_busy` is 0. It is 0 after any edge where `tx_busy` was 1 or a write occurred.
- R4: With `fifo_en`=1, an accepted write stores the byte in the FIFO and increments `fifo_cnt`. A `fifo_cnt` of 0 means the FIFO holds no data.
- R5: With `fifo_en`=1, when the holding register is empty and `fifo_cnt`>0, the oldest FIFO byte enters the holding register at the next edge and `fifo_cnt` drops by one.
- R6: With `fifo_en`=1, `tdre` is 1 only when both the holding register and the FIFO are empty.
- R7: `drq` sets at the edge where `fifo_cnt` goes from nonzero to 0. It clears on `drq_clr` or when `fifo_cnt` reaches DEPTH. A set in the same cycle as `drq_clr` wins.
- R8: A write while `fifo_cnt`=DEPTH is dropped and leaves `fifo_cnt` at DEPTH.
- R9: `irq` is 1 exactly when (`tdre` and `tdre_ie`), (`tbi` and `tbi_ie`) or (`drq` and `drq_ie`) holds. It follows the enables in the same cycle.
- R10: Driving `fifo_en` to 0 empties the FIFO and clears `drq` at the next edge. Later writes then go to the holding register.
- R11: Bytes leave the FIFO into the holding register in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: writes go through the FIFO; 0: direct to holding register, FIFO flushed |
| wr_en | input | 1 | CPU data write strobe |
| wr_data | input | DW | CPU write data |
| load_stb | input | 1 | Serializer has taken the holding byte |
| tx_busy | input | 1 | Serializer is shifting a frame |
| drq_clr | input | 1 | Software write of 0 to the data-request flag |
| tdre_ie | input | 1 | Holding-empty interrupt enable |
| tbi_ie | input | 1 | Bus-idle interrupt enable |
| drq_ie | input | 1 | FIFO data-request interrupt enable |
| hold_data | output | DW | Holding register contents |
| hold_vld | output | 1 | Holding register full |
| tdre | output | 1 | Holding-empty flag |
| tbi | output | 1 | Bus-idle flag |
| drq | output | 1 | FIFO data-request flag |
| fifo_cnt | output | $clog2(DEPTH+1) | Bytes held in the FIFO |
| irq | output | 1 | Combined transmit interrupt request |

## Verification
Every flag, the count and the holding register update at the first clock edge after the cycle that holds the stimulus. The one exception is a FIFO-to-holding transfer, which needs one further edge after the holding register empties, so the byte is due two edges after a `load_stb`. `irq` is combinational from the flags and the enables, so it is due in the same cycle as the flag it reflects. The driver queues each expectation with the edge count at which it falls due. The monitor compares only at the falling edge after that count is reached, so no check samples the design during its own edge.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef struct packed {
    logic hold_empty;
    logic bus_idle;
    logic data_req;
  } txq_flags_t;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push_req,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop_req,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_nxt
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, wp_nxt, rp, rp_nxt;
  logic          push, pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    push    = push_req & ~flush & (cnt != CW'(DEPTH));
    pop     = pop_req  & ~flush & (cnt != '0);
    wp_nxt  = flush ? '0 : (push ? bump(wp) : wp);
    rp_nxt  = flush ? '0 : (pop  ? bump(rp) : rp);
    cnt_nxt = flush ? '0 : cnt + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_nxt;
      rp  <= rp_nxt;
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  assign head = mem[rp];

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push_req && !pop_req && cnt == CW'(DEPTH)) |=> cnt == CW'(DEPTH));
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == '0);
endmodule

// File: rtl/txq_hold.sv
module txq_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          load_stb,
  input  logic [DW-1:0] fifo_head,
  input  logic          fifo_has,
  output logic          pop,
  output logic          full,
  output logic          full_nxt,
  output logic [DW-1:0] data
);
  logic          direct_wr, data_en;
  logic [DW-1:0] data_nxt;

  always_comb begin
    direct_wr = ~fifo_en & wr_en;
    pop       = fifo_en & ~full & fifo_has;
    full_nxt  = direct_wr | pop | (full & ~load_stb);
    data_en   = direct_wr | pop;
    data_nxt  = pop ? fifo_head : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data <= '0;
    else if (data_en) data <= data_nxt;
  end

  p_pop_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> full);
  p_load_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && load_stb && !direct_wr) |=> !full);
endmodule

// File: rtl/txq_flags.sv
module txq_flags
  import txq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       hold_full_nxt,
  input  logic       cnt_zero,
  input  logic       cnt_nxt_zero,
  input  logic       cnt_nxt_full,
  input  logic       tx_busy,
  input  logic       drq_clr,
  input  logic [2:0] ie,
  output txq_flags_t flags,
  output logic       irq
);
  txq_flags_t nxt;
  logic       drq_set, drq_kill, drq_we;

  always_comb begin
    nxt.hold_empty = ~hold_full_nxt & cnt_nxt_zero;
    nxt.bus_idle   = nxt.hold_empty & ~tx_busy;
    drq_set        = fifo_en & ~cnt_zero & cnt_nxt_zero;
    drq_kill       = ~fifo_en | cnt_nxt_full | drq_clr;
    drq_we         = drq_set | drq_kill;
    nxt.data_req   = drq_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags.hold_empty <= 1'b1;
      flags.bus_idle   <= 1'b0;
    end else begin
      flags.hold_empty <= nxt.hold_empty;
      flags.bus_idle   <= nxt.bus_idle;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags.data_req <= 1'b0;
    else if (drq_we) flags.data_req <= nxt.data_req;
  end

  assign irq = |({flags.hold_empty, flags.bus_idle, flags.data_req} & ie);

  p_busy_blocks_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |=> !flags.bus_idle);
  p_full_kills_drq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_nxt_full |=> !flags.data_req);
  p_drq_needs_fifo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !flags.data_req);
endmodule

// File: rtl/txq_status.sv
module txq_status
  import txq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fifo_en,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       load_stb,
  input  logic                       tx_busy,
  input  logic                       drq_clr,
  input  logic                       tdre_ie,
  input  logic                       tbi_ie,
  input  logic                       drq_ie,
  output logic [DW-1:0]              hold_data,
  output logic                       hold_vld,
  output logic                       tdre,
  output logic                       tbi,
  output logic                       drq,
  output logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  output logic                       irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] head;
  logic [CW-1:0] cnt_nxt;
  logic          pop, full_nxt;
  txq_flags_t    flags;

  txq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (~fifo_en),
    .push_req  (fifo_en & wr_en),
    .push_data (wr_data),
    .pop_req   (pop),
    .head      (head),
    .cnt       (fifo_cnt),
    .cnt_nxt   (cnt_nxt)
  );

  txq_hold #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_en   (fifo_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .load_stb  (load_stb),
    .fifo_head (head),
    .fifo_has  (fifo_cnt != '0),
    .pop       (pop),
    .full      (hold_vld),
    .full_nxt  (full_nxt),
    .data      (hold_data)
  );

  txq_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_en       (fifo_en),
    .hold_full_nxt (full_nxt),
    .cnt_zero      (fifo_cnt == '0),
    .cnt_nxt_zero  (cnt_nxt == '0),
    .cnt_nxt_full  (cnt_nxt == CW'(DEPTH)),
    .tx_busy       (tx_busy),
    .drq_clr       (drq_clr),
    .ie            ({tdre_ie, tbi_ie, drq_ie}),
    .flags         (flags),
    .irq           (irq)
  );

  assign tdre = flags.hold_empty;
  assign tbi  = flags.bus_idle;
  assign drq  = flags.data_req;

  p_wr_clears_tdre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tdre);
  p_wr_clears_tbi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !tbi);
  p_tdre_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tdre && tdre_ie) |-> irq);
  p_tdre_both_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tdre |-> (!hold_vld && fifo_cnt == '0));
endmodule

// File: tb/tb_txq_status.sv
module tb_txq_status;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH+1);

  localparam int S_TDRE = 0, S_TBI = 1, S_DRQ = 2, S_CNT = 3,
                 S_IRQ = 4, S_DATA = 5, S_VLD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 0, wr_en = 0, load_stb = 0, tx_busy = 0, drq_clr = 0;
  logic tdre_ie = 0, tbi_ie = 0, drq_ie = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] hold_data;
  logic hold_vld, tdre, tbi, drq, irq;
  logic [CW-1:0] fifo_cnt;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  typedef struct { int due; int sel; int val; string req; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  txq_status #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr_en(wr_en),
    .wr_data(wr_data), .load_stb(load_stb), .tx_busy(tx_busy),
    .drq_clr(drq_clr), .tdre_ie(tdre_ie), .tbi_ie(tbi_ie), .drq_ie(drq_ie),
    .hold_data(hold_data), .hold_vld(hold_vld), .tdre(tdre), .tbi(tbi),
    .drq(drq), .fifo_cnt(fifo_cnt), .irq(irq)
  );

  function automatic int actual(input int sel);
    case (sel)
      S_TDRE: return int'(tdre);
      S_TBI:  return int'(tbi);
      S_DRQ:  return int'(drq);
      S_CNT:  return int'(fifo_cnt);
      S_IRQ:  return int'(irq);
      S_DATA: return int'(hold_data);
      default: return int'(hold_vld);
    endcase
  endfunction

  // driver side: expectation falls due one edge after the current cycle
  task automatic expect1(input string req, input int sel, input int val);
    exp_t e;
    e.due = cyc + 1; e.sel = sel; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  // monitor: compare items that have fallen due
  always @(negedge clk) begin : mon
    int i;
    i = 0;
    while (i < q.size()) begin
      if (q[i].due <= cyc) begin
        total++;
        if (actual(q[i].sel) != q[i].val) begin
          bad++;
          $display("FAIL %s sel=%0d actual=%0h expected=%0h", q[i].req,
                   q[i].sel, actual(q[i].sel), q[i].val);
        end
        q.delete(i);
      end else i++;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : drive
    cycle();
    // R1 reset values
    expect1("R1", S_TDRE, 1); expect1("R1", S_TBI, 0); expect1("R1", S_DRQ, 0);
    expect1("R1", S_CNT, 0);  expect1("R1", S_IRQ, 0); expect1("R1", S_VLD, 0);
    cycle(); cycle();
    rst_n = 1'b1;
    expect1("R3", S_TBI, 1);
    cycle();

    // R2 direct write
    wr_en = 1; wr_data = 8'hA5;
    expect1("R2", S_TDRE, 0); expect1("R3", S_TBI, 0);
    expect1("R2", S_VLD, 1);  expect1("R2", S_DATA, 8'hA5);
    cycle(); wr_en = 0;
    // R2 load empties holding, R3 busy keeps idle low
    load_stb = 1; tx_busy = 1;
    expect1("R2", S_TDRE, 1); expect1("R3", S_TBI, 0); expect1("R2", S_VLD, 0);
    cycle(); load_stb = 0;
    expect1("R3", S_TBI, 0);
    cycle();
    tx_busy = 0; tdre_ie = 1;
    expect1("R3", S_TBI, 1); expect1("R9", S_IRQ, 1);
    cycle();
    // R9 bus-idle source alone; R2 load on empty ignored
    tdre_ie = 0; tbi_ie = 1; load_stb = 1;
    expect1("R9", S_IRQ, 1); expect1("R2", S_TDRE, 1); expect1("R2", S_VLD, 0);
    cycle(); load_stb = 0;
    wr_en = 1; wr_data = 8'h3C;
    expect1("R3", S_TBI, 0); expect1("R9", S_IRQ, 0);
    expect1("R2", S_TDRE, 0); expect1("R2", S_DATA, 8'h3C);
    cycle(); wr_en = 0;
    tbi_ie = 0; load_stb = 1; tx_busy = 1;
    expect1("R2", S_TDRE, 1);
    cycle(); load_stb = 0;

    // FIFO mode, three bytes
    fifo_en = 1;
    cycle();
    for (int k = 0; k < 3; k++) begin
      wr_en = 1; wr_data = 8'h10 + 8'(k);
      if (k == 0) begin expect1("R4", S_CNT, 1); expect1("R6", S_TDRE, 0); end
      if (k == 1) begin expect1("R5", S_DATA, 8'h10); expect1("R4", S_CNT, 1); end
      if (k == 2) expect1("R4", S_CNT, 2);
      cycle();
    end
    wr_en = 0;
    load_stb = 1;
    expect1("R6", S_TDRE, 0); expect1("R5", S_VLD, 0); expect1("R5", S_CNT, 2);
    cycle(); load_stb = 0;
    expect1("R5", S_DATA, 8'h11); expect1("R5", S_CNT, 1);
    cycle();
    load_stb = 1;
    cycle(); load_stb = 0;
    expect1("R11", S_DATA, 8'h12); expect1("R7", S_DRQ, 1);
    expect1("R4", S_CNT, 0); expect1("R6", S_TDRE, 0);
    cycle();
    drq_ie = 1;
    expect1("R9", S_IRQ, 1);
    cycle();
    load_stb = 1;
    expect1("R6", S_TDRE, 1);
    cycle(); load_stb = 0;
    drq_clr = 1;
    expect1("R7", S_DRQ, 0); expect1("R9", S_IRQ, 0);
    cycle(); drq_clr = 0; drq_ie = 0;

    // fill to DEPTH, then drop one
    wr_en = 1; wr_data = 8'h20;
    cycle(); wr_en = 0;
    expect1("R7", S_DRQ, 1); expect1("R5", S_DATA, 8'h20);
    cycle();
    for (int k = 0; k <= DEPTH; k++) begin
      wr_en = 1; wr_data = 8'h21 + 8'(k);
      if (k == DEPTH-1) begin expect1("R7", S_CNT, DEPTH); expect1("R7", S_DRQ, 0); end
      if (k == DEPTH) expect1("R8", S_CNT, DEPTH);
      cycle();
    end
    wr_en = 0;

    // drain in order; set beats clear on the final pop
    for (int k = 0; k < DEPTH; k++) begin
      load_stb = 1;
      cycle(); load_stb = 0;
      if (k == DEPTH-1) begin
        drq_clr = 1;
        expect1("R7", S_DRQ, 1); expect1("R4", S_CNT, 0);
      end
      expect1("R11", S_DATA, 8'h21 + k);
      cycle(); drq_clr = 0;
    end

    // R10 leaving FIFO mode flushes
    wr_en = 1; wr_data = 8'h31;
    cycle(); wr_data = 8'h32;
    expect1("R4", S_CNT, 2);
    cycle(); wr_en = 0;
    fifo_en = 0;
    expect1("R10", S_CNT, 0); expect1("R10", S_DRQ, 0);
    cycle();
    wr_en = 1; wr_data = 8'h77;
    expect1("R10", S_DATA, 8'h77); expect1("R10", S_CNT, 0);
    cycle(); wr_en = 0;
    cycle(); cycle();

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule